// File: doc/BRIEF.md
# Sticky Alarm Collector with Mid-Scale Output Muting

This block gathers single-cycle fault pulses from the surrounding converter datapath into one 16-bit status word. The pulses come from the clock-loss monitors, the FIFO pointer watcher, the PLL lock monitor, the data pattern checker, the FIFO pointer zero check and four parity checkers. Each recorded bit stays set until software writes a 1 to it. Events that arrive in the same cycle as that write win over the clear. A derived "output lost" bit reports whether a sample-clock loss, a data-clock loss or a FIFO pointer collision is pending.

While any of those three conditions is pending and its shutdown enable is set, the block replaces every output sample on every channel with mid-scale (0x8000 for 16-bit samples). The mute register follows the status word by one cycle. The output stays muted until the fault has gone and the bit has been cleared.

The parity bits take their meaning from a mode select. In dual-parity mode each of the four bits reports one data word, A to D. In single-parity mode bit A reports the word captured on the rising clock edge, bit B reports the word captured on the falling edge, and bits C and D are never set.

Top module: `alarm_mute_agg`

## Requirements
- R1: After reset `rd_data` reads 0 and `smp_out` equals `smp_in`.
- R2: A pulse on an event input sets its status bit at the next clock edge, and the bit holds with the input low. Bit positions: 15 `evt_zero_chk`, 10 `evt_dacclk_gone`, 9 `evt_dataclk_gone`, 7 `evt_pattern`, 5 `evt_pll_unlock`.
- R3: Each bit of `evt_fifo_code` is sticky on its own. Bit 2 (collision) maps to status bit 13, bit 1 (one apart) to bit 12 and bit 0 (two apart) to bit 11.
- R4: Status bit 8 reads 1 exactly when bit 10, 9 or 13 is set. Bit 8 cannot be written.
- R5: A write with `wr_en` high clears every sticky bit whose `wr_data` bit is 1, visible after the next edge. Bits written with 0 keep their value.
- R6: An event in the same cycle as a clear write of its bit leaves the bit set.
- R7: When status bit 10 is set with `sd_en_dacclk`, bit 9 with `sd_en_dataclk`, or bit 13 with `sd_en_collision`, every channel of `smp_out` is 0x8000 from the cycle after. `smp_out` returns to `smp_in` the cycle after no such pair remains.
- R8: A status bit whose shutdown enable is low is still recorded but does not mute the output.
- R9: With `par_single` low, `par_err_word[0..3]` (words A..D) set status bits 4, 3, 2 and 1, and `par_err_edge` is ignored.
- R10: With `par_single` high, `par_err_edge[0]` (rising-edge word) sets bit 4 and `par_err_edge[1]` (falling-edge word) sets bit 3. `par_err_word` is ignored and bits 2 and 1 are never set.
- R11: Bits 14, 6 and 0 always read 0, even after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_zero_chk | input | 1 | FIFO write pointer zero-pattern event |
| evt_fifo_code | input | 3 | FIFO nearness events: [2] collision, [1] one apart, [0] two apart |
| evt_dacclk_gone | input | 1 | Sample clock lost event |
| evt_dataclk_gone | input | 1 | Data clock lost event |
| evt_pattern | input | 1 | Pattern checker mismatch event |
| evt_pll_unlock | input | 1 | PLL lock lost event |
| par_single | input | 1 | 1 = single-parity mode, 0 = dual-parity mode |
| par_err_word | input | 4 | Dual-mode parity errors, [0]=A .. [3]=D |
| par_err_edge | input | 2 | Single-mode parity errors, [0]=rising word, [1]=falling word |
| sd_en_dacclk | input | 1 | Shutdown enable for sample clock loss |
| sd_en_dataclk | input | 1 | Shutdown enable for data clock loss |
| sd_en_collision | input | 1 | Shutdown enable for FIFO collision |
| wr_en | input | 1 | Clear-write strobe |
| wr_data | input | 16 | Write-1-to-clear mask |
| smp_in | input | NCH*SW | Incoming samples, channel 0 in the low bits |
| rd_data | output | 16 | Status word readback |
| smp_out | output | NCH*SW | Samples after muting |

## Verification
The bench goes after an event that arrives in the same cycle as the clear write of its bit. A design that let the clear win would drop a fault that had just occurred. It arms a fault with its shutdown enable low and then raises the enable while the bit is still set. A design that latched the enable only at event time would never mute, and one that ignored the enable would mute too early. It switches parity modes with errors driven on the input that should be ignored, which exposes swapped A/B mapping or C/D bits leaking in single mode. It counts the exact mute and release cycles, so an extra or missing pipeline stage shows up as a mismatched sample.

// File: rtl/alarm_agg_pkg.sv
package alarm_agg_pkg;

  localparam int unsigned STAT_W = 16;

  // status bit positions
  localparam int unsigned B_ZERO    = 15;
  localparam int unsigned B_FCOLL   = 13;
  localparam int unsigned B_FNEAR1  = 12;
  localparam int unsigned B_FNEAR2  = 11;
  localparam int unsigned B_DACCLK  = 10;
  localparam int unsigned B_DATACLK = 9;
  localparam int unsigned B_OUTGONE = 8;
  localparam int unsigned B_PATTERN = 7;
  localparam int unsigned B_PLL     = 5;
  localparam int unsigned B_PAR_A   = 4;
  localparam int unsigned B_PAR_B   = 3;
  localparam int unsigned B_PAR_C   = 2;
  localparam int unsigned B_PAR_D   = 1;

  // bits that hold a sticky flop (derived and reserved bits excluded)
  localparam logic [STAT_W-1:0] STICKY_MASK = 16'hBEBE;

  // parity mapping: returns {A,B,C,D}
  function automatic logic [3:0] parity_bits(input logic single,
                                             input logic [3:0] word_err,
                                             input logic [1:0] edge_err);
    logic [3:0] r;
    if (single) r = {edge_err[0], edge_err[1], 2'b00};
    else        r = {word_err[0], word_err[1], word_err[2], word_err[3]};
    return r;
  endfunction

  // mute request from the registered status and the enables
  function automatic logic mute_request(input logic [STAT_W-1:0] st,
                                        input logic en_dac,
                                        input logic en_dat,
                                        input logic en_col);
    return (st[B_DACCLK] & en_dac) | (st[B_DATACLK] & en_dat) |
           (st[B_FCOLL] & en_col);
  endfunction

  function automatic logic out_gone(input logic [STAT_W-1:0] st);
    return st[B_DACCLK] | st[B_DATACLK] | st[B_FCOLL];
  endfunction

endpackage

// File: rtl/alarm_event_map.sv
module alarm_event_map
  import alarm_agg_pkg::*;
(
  input  logic              evt_zero_chk,
  input  logic [2:0]        evt_fifo_code,
  input  logic              evt_dacclk_gone,
  input  logic              evt_dataclk_gone,
  input  logic              evt_pattern,
  input  logic              evt_pll_unlock,
  input  logic              par_single,
  input  logic [3:0]        par_err_word,
  input  logic [1:0]        par_err_edge,
  output logic [STAT_W-1:0] set_vec
);

  logic [3:0] par_abcd;

  always_comb begin
    par_abcd = parity_bits(par_single, par_err_word, par_err_edge);
    set_vec            = '0;
    set_vec[B_ZERO]    = evt_zero_chk;
    set_vec[B_FCOLL]   = evt_fifo_code[2];
    set_vec[B_FNEAR1]  = evt_fifo_code[1];
    set_vec[B_FNEAR2]  = evt_fifo_code[0];
    set_vec[B_DACCLK]  = evt_dacclk_gone;
    set_vec[B_DATACLK] = evt_dataclk_gone;
    set_vec[B_PATTERN] = evt_pattern;
    set_vec[B_PLL]     = evt_pll_unlock;
    set_vec[B_PAR_A]   = par_abcd[3];
    set_vec[B_PAR_B]   = par_abcd[2];
    set_vec[B_PAR_C]   = par_abcd[1];
    set_vec[B_PAR_D]   = par_abcd[0];
  end

endmodule

// File: rtl/alarm_status_reg.sv
module alarm_status_reg
  import alarm_agg_pkg::*;
#(
  parameter logic [STAT_W-1:0] MASK = STICKY_MASK
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] status_q
);

  logic [STAT_W-1:0] clr_vec;
  assign clr_vec = wr_en ? wr_data : '0;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (MASK[i]) begin : g_sticky
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~clr_vec[i]) | set_vec[i];
      end
      assign status_q[i] = q;
    end else begin : g_none
      assign status_q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/alarm_mute_ctrl.sv
module alarm_mute_ctrl
  import alarm_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_q,
  input  logic              sd_en_dacclk,
  input  logic              sd_en_dataclk,
  input  logic              sd_en_collision,
  output logic              outgone,
  output logic              mute_q
);

  assign outgone = out_gone(status_q);

  always_ff @(posedge clk) begin
    if (!rst_n) mute_q <= 1'b0;
    else        mute_q <= mute_request(status_q, sd_en_dacclk,
                                       sd_en_dataclk, sd_en_collision);
  end

endmodule

// File: rtl/sample_mute_mux.sv
module sample_mute_mux #(
  parameter int unsigned NCH = 4,
  parameter int unsigned SW  = 16
)(
  input  logic              mute,
  input  logic [NCH*SW-1:0] smp_in,
  output logic [NCH*SW-1:0] smp_out
);

  localparam logic [SW-1:0] MID = {1'b1, {(SW-1){1'b0}}};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign smp_out[c*SW +: SW] = mute ? MID : smp_in[c*SW +: SW];
  end

endmodule

// File: rtl/alarm_mute_agg.sv
module alarm_mute_agg
  import alarm_agg_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned SW  = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_zero_chk,
  input  logic [2:0]        evt_fifo_code,
  input  logic              evt_dacclk_gone,
  input  logic              evt_dataclk_gone,
  input  logic              evt_pattern,
  input  logic              evt_pll_unlock,
  input  logic              par_single,
  input  logic [3:0]        par_err_word,
  input  logic [1:0]        par_err_edge,
  input  logic              sd_en_dacclk,
  input  logic              sd_en_dataclk,
  input  logic              sd_en_collision,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic [NCH*SW-1:0] smp_in,
  output logic [15:0]       rd_data,
  output logic [NCH*SW-1:0] smp_out
);

  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] status_q;
  logic              outgone;
  logic              mute;

  alarm_event_map u_map (
    .evt_zero_chk     (evt_zero_chk),
    .evt_fifo_code    (evt_fifo_code),
    .evt_dacclk_gone  (evt_dacclk_gone),
    .evt_dataclk_gone (evt_dataclk_gone),
    .evt_pattern      (evt_pattern),
    .evt_pll_unlock   (evt_pll_unlock),
    .par_single       (par_single),
    .par_err_word     (par_err_word),
    .par_err_edge     (par_err_edge),
    .set_vec          (set_vec)
  );

  alarm_status_reg #(.MASK(STICKY_MASK)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .status_q (status_q)
  );

  alarm_mute_ctrl u_mute (
    .clk             (clk),
    .rst_n           (rst_n),
    .status_q        (status_q),
    .sd_en_dacclk    (sd_en_dacclk),
    .sd_en_dataclk   (sd_en_dataclk),
    .sd_en_collision (sd_en_collision),
    .outgone         (outgone),
    .mute_q          (mute)
  );

  sample_mute_mux #(.NCH(NCH), .SW(SW)) u_mux (
    .mute    (mute),
    .smp_in  (smp_in),
    .smp_out (smp_out)
  );

  always_comb begin
    rd_data            = status_q;
    rd_data[B_OUTGONE] = outgone;
  end

endmodule

// File: rtl/alarm_mute_agg_chk.sv
module alarm_mute_agg_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned SW  = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              evt_dacclk_gone,
  input logic              evt_dataclk_gone,
  input logic              par_single,
  input logic              sd_en_dacclk,
  input logic              sd_en_dataclk,
  input logic              sd_en_collision,
  input logic              wr_en,
  input logic [15:0]       wr_data,
  input logic [15:0]       rd_data,
  input logic [NCH*SW-1:0] smp_in,
  input logic [NCH*SW-1:0] smp_out
);

  localparam logic [SW-1:0]     MID     = {1'b1, {(SW-1){1'b0}}};
  localparam logic [NCH*SW-1:0] ALL_MID = {NCH{MID}};

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n) evt_dataclk_gone |=> rd_data[9]); // R2
  AST_OUTGONE_DERIVED: assert property (@(posedge clk) disable iff (!rst_n) rd_data[10] |-> rd_data[8]); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_data[9] && !evt_dataclk_gone) |=> !rd_data[9]); // R5
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (evt_dacclk_gone && wr_en && wr_data[10]) |=> rd_data[10]); // R6
  AST_MUTE_ON: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[10] && sd_en_dacclk) |=> (smp_out == ALL_MID)); // R7
  AST_MUTE_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!rd_data[10] && !rd_data[9] && !rd_data[13]) |=> (smp_out == smp_in)); // R7
  AST_DISABLED_NO_MUTE: assert property (@(posedge clk) disable iff (!rst_n) (!sd_en_dacclk && !sd_en_dataclk && !sd_en_collision) |=> (smp_out == smp_in)); // R8
  AST_SINGLE_CD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (par_single && !rd_data[2] && !rd_data[1]) |=> (!rd_data[2] && !rd_data[1])); // R10
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (!rd_data[14] && !rd_data[6] && !rd_data[0])); // R11

endmodule

bind alarm_mute_agg alarm_mute_agg_chk #(.NCH(NCH), .SW(SW)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .evt_dacclk_gone  (evt_dacclk_gone),
  .evt_dataclk_gone (evt_dataclk_gone),
  .par_single       (par_single),
  .sd_en_dacclk     (sd_en_dacclk),
  .sd_en_dataclk    (sd_en_dataclk),
  .sd_en_collision  (sd_en_collision),
  .wr_en            (wr_en),
  .wr_data          (wr_data),
  .rd_data          (rd_data),
  .smp_in           (smp_in),
  .smp_out          (smp_out)
);

// File: tb/test_alarm_mute_agg.sv
`timescale 1ns/1ps
module test_alarm_mute_agg;

  localparam int NCH = 4;
  localparam int SW  = 16;
  localparam logic [NCH*SW-1:0] ALL_MID = {NCH{16'h8000}};

  // ev encoding used by the driver:
  // [0] zero  [1] dacclk  [2] dataclk  [3] pattern  [4] pll
  // [7:5] fifo code  [11:8] word parity A..D  [13:12] edge parity rise/fall
  localparam logic [15:0] EV_ZERO = 16'h0001, EV_DAC = 16'h0002, EV_DAT = 16'h0004;
  localparam logic [15:0] EV_PAT = 16'h0008, EV_PLL = 16'h0010;

  logic clk = 0, rst_n = 0;
  logic evt_zero_chk = 0, evt_dacclk_gone = 0, evt_dataclk_gone = 0;
  logic evt_pattern = 0, evt_pll_unlock = 0, par_single = 0;
  logic [2:0] evt_fifo_code = 0;
  logic [3:0] par_err_word = 0;
  logic [1:0] par_err_edge = 0;
  logic sd_en_dacclk = 1, sd_en_dataclk = 1, sd_en_collision = 1;
  logic wr_en = 0;
  logic [15:0] wr_data = 0;
  logic [NCH*SW-1:0] smp_in = 0;
  logic [15:0] rd_data;
  logic [NCH*SW-1:0] smp_out;

  always #10 clk = ~clk;

  alarm_mute_agg #(.NCH(NCH), .SW(SW)) i_alarm_mute_agg (.*);

  typedef struct {
    int unsigned       due;
    string             tag;
    logic [15:0]       rd;
    logic [NCH*SW-1:0] out;
  } item_t;

  item_t sbq[$];
  int unsigned cyc = 0;
  int checks = 0, failures = 0;
  logic [15:0] m_st = 0;  // model sticky bits, bit 8 kept 0
  logic mode_s = 0, en_dac_s = 1, en_dat_s = 1, en_col_s = 1;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops and compares items that fall due at this falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (rd_data !== it.rd) begin
        failures++;
        $display("FAIL %s rd_data actual=%h expected=%h", it.tag, rd_data, it.rd);
      end
      checks++;
      if (smp_out !== it.out) begin
        failures++;
        $display("FAIL %s smp_out actual=%h expected=%h", it.tag, smp_out, it.out);
      end
    end
  end

  // driver: applies one cycle of stimulus and pushes the expected outcome
  task automatic tick(input string tag, input logic [15:0] ev,
                      input logic wr = 0, input logic [15:0] wd = 0);
    logic [15:0] setb;
    logic mute_n;
    item_t it;
    @(negedge clk); #1;
    evt_zero_chk = ev[0]; evt_dacclk_gone = ev[1]; evt_dataclk_gone = ev[2];
    evt_pattern = ev[3]; evt_pll_unlock = ev[4]; evt_fifo_code = ev[7:5];
    par_err_word = ev[11:8]; par_err_edge = ev[13:12];
    par_single = mode_s; sd_en_dacclk = en_dac_s; sd_en_dataclk = en_dat_s;
    sd_en_collision = en_col_s; wr_en = wr; wr_data = wd;
    smp_in = {$urandom(), $urandom()};
    setb = 0;
    if (ev[0]) setb[15] = 1;
    if (ev[1]) setb[10] = 1;
    if (ev[2]) setb[9] = 1;
    if (ev[3]) setb[7] = 1;
    if (ev[4]) setb[5] = 1;
    if (ev[7]) setb[13] = 1;
    if (ev[6]) setb[12] = 1;
    if (ev[5]) setb[11] = 1;
    if (!mode_s) begin
      if (ev[8])  setb[4] = 1;
      if (ev[9])  setb[3] = 1;
      if (ev[10]) setb[2] = 1;
      if (ev[11]) setb[1] = 1;
    end else begin
      if (ev[12]) setb[4] = 1;
      if (ev[13]) setb[3] = 1;
    end
    mute_n = (m_st[10] && en_dac_s) || (m_st[9] && en_dat_s) || (m_st[13] && en_col_s);
    if (wr) m_st = m_st & ~wd;
    m_st = m_st | setb;
    it.due = cyc + 1;
    it.tag = tag;
    it.rd  = m_st;
    it.rd[8] = m_st[10] | m_st[9] | m_st[13];
    it.out = mute_n ? ALL_MID : smp_in;
    sbq.push_back(it);
  endtask

  task automatic idle(input string tag, input int n);
    for (int k = 0; k < n; k++) tick(tag, 16'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    smp_in = 64'h1234_5678_9ABC_DEF0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if (rd_data !== 16'h0) begin
      failures++; $display("FAIL R1 rd_data actual=%h expected=0000", rd_data);
    end
    checks++;
    if (smp_out !== smp_in) begin
      failures++; $display("FAIL R1 smp_out actual=%h expected=%h", smp_out, smp_in);
    end
    rst_n = 1;
    idle("R1", 2);

    // R2: individual events, held after pulse, then cleared (R5)
    tick("R2", EV_ZERO); idle("R2", 2);
    tick("R2", EV_PAT);  tick("R2", EV_PLL); idle("R2", 1);
    tick("R5", 16'h0, 1, 16'h0020);          // clear only PLL, others held
    tick("R5", 16'h0, 1, 16'h8080);
    idle("R5", 1);

    // R7: sample clock loss mutes, clear releases
    tick("R7", EV_DAC); idle("R7", 3);
    tick("R7", 16'h0, 1, 16'h0400); idle("R7", 2);
    // R7: data clock loss
    tick("R7", EV_DAT); idle("R7", 2);
    tick("R7", 16'h0, 1, 16'h0200); idle("R7", 2);

    // R3/R4: FIFO codes, collision mutes
    tick("R3", 16'h0020); tick("R3", 16'h0040); idle("R3", 1);
    tick("R4", 16'h0080); idle("R4", 3);
    tick("R4", 16'h0, 1, 16'h3900); idle("R4", 2);   // bit 8 write is no-op

    // R6: event in same cycle as clear
    tick("R6", EV_DAC, 1, 16'h0400); idle("R6", 2);
    tick("R6", EV_DAC); idle("R6", 1);
    tick("R6", EV_DAC, 1, 16'h0400); idle("R6", 1);
    tick("R6", 16'h0, 1, 16'h0400); idle("R6", 2);

    // R8: disabled enable records but does not mute; enabling later mutes
    en_dac_s = 0; en_col_s = 0;
    tick("R8", EV_DAC | 16'h0080); idle("R8", 3);
    en_dac_s = 1; idle("R8", 3);
    tick("R8", 16'h0, 1, 16'h0400); idle("R8", 2);
    en_col_s = 1; idle("R8", 2);
    tick("R8", 16'h0, 1, 16'h2000); idle("R8", 2);

    // R9: dual-parity mapping, edge inputs ignored
    mode_s = 0;
    tick("R9", 16'h3000); idle("R9", 1);
    tick("R9", 16'h0100); tick("R9", 16'h0200);
    tick("R9", 16'h0400); tick("R9", 16'h0800); idle("R9", 1);
    tick("R9", 16'h0, 1, 16'h001E); idle("R9", 1);

    // R10: single-parity mapping, word inputs ignored
    mode_s = 1;
    tick("R10", 16'h0F00); idle("R10", 1);
    tick("R10", 16'h1000); idle("R10", 1);
    tick("R10", 16'h2000); idle("R10", 1);
    tick("R10", 16'h0, 1, 16'h0018); idle("R10", 1);
    mode_s = 0;

    // R11: write all ones, reserved bits stay 0
    tick("R11", 16'h3FFF & ~16'h3000); idle("R11", 1);
    tick("R11", 16'h0, 1, 16'hFFFF); idle("R11", 3);

    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule